// File: doc/BRIEF.md
# Pin-to-Resource Routing Matrix

This block lets any of ten general-purpose pins, plus a dedicated push-button input, drive one of three internal resources: the count clock of timer 0, the count clock of timer 1, and a high-priority interrupt request. Each source has its own 3-bit destination code. When several sources name the same destination, that destination sees the logical OR of all of them.

The block looks only at the level on each pad. A pin that the chip drives as an output can therefore still be counted by a timer or can still raise the interrupt. Pad levels pass through a two-flop synchronizer before the merge stage. Destination codes come straight from configuration registers and are decoded combinationally. The timers, the interrupt controller and any edge detection are outside this block.

Top module: `pin_route_matrix`

## Requirements
- R1: While rst_n is low, tmr0_clk, tmr1_clk and irq_hi are all 0, whatever the pin levels and codes.
- R2: A source whose code is 0 (no route) or 1 (reserved) drives no destination.
- R3: A source whose code is 2 drives tmr0_clk. Code 3 drives tmr1_clk. Code 4 drives irq_hi.
- R4: A source whose code is 5, 6 or 7 drives no destination.
- R5: Each destination output is the OR of the synchronized levels of every source whose code names it. Sources that name other destinations have no effect on it.
- R6: The push-button level pb_lvl is routed by pb_sel with the same code meanings as the pins.
- R7: A pad level change appears at the outputs after two rising clock edges. A code change takes effect without a clock edge.
- R8: Pin k (pin_lvl[k], k = 0..9) is routed by the code field pin_sel[3k+2:3k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 10 | Pad levels of the routable pins |
| pb_lvl | input | 1 | Push-button pad level |
| pin_sel | input | 30 | Packed 3-bit destination codes, one per pin |
| pb_sel | input | 3 | Destination code of the push-button |
| tmr0_clk | output | 1 | Count clock to timer 0 |
| tmr1_clk | output | 1 | Count clock to timer 1 |
| irq_hi | output | 1 | High-priority interrupt request |

## Verification
The bench runs every source through all eight codes at both levels. Every other source is held at code 0 during this sweep. A design that decodes the reserved code or the high codes 5 to 7 as a destination lights the wrong output here. So does a design that swaps two code fields in the packed selector.

Pseudo-random mixes of levels and codes then check the OR merge where sources collide. A design that lets the last source win, or that leaks one destination into another, fails these mixes.

The bench also samples each output once after the first clock edge and again after the second. A design with one synchronizer stage shows up on the early sample. So does a design that registers the code path. A design whose synchronizer holds stale data through reset is caught by the check taken while reset is low.

// File: rtl/route_pkg.sv
package route_pkg;
   localparam int NDEST = 3;
   localparam int CODE_W = 3;
   localparam logic [CODE_W-1:0] CODE_TMR0 = 3'd2;
   localparam logic [CODE_W-1:0] CODE_TMR1 = 3'd3;
   localparam logic [CODE_W-1:0] CODE_IRQ  = 3'd4;

   // destination index -> code that selects it
   function automatic logic [CODE_W-1:0] dest_code(input int idx);
      case (idx)
         0:       return CODE_TMR0;
         1:       return CODE_TMR1;
         default: return CODE_IRQ;
      endcase
   endfunction
endpackage

// File: rtl/route_sync.sv
module route_sync #(
   parameter int W      = 11,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("route_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/route_decode.sv
module route_decode
   import route_pkg::*;
#(
   parameter int SEL_W = CODE_W
) (
   input  logic             lvl,
   input  logic [SEL_W-1:0] sel,
   output logic [NDEST-1:0] hit
);
   generate
      if (SEL_W != CODE_W) begin : g_bad
         $error("route_decode code width mismatch");
      end
   endgenerate

   for (genvar d = 0; d < NDEST; d++) begin : g_dst
      assign hit[d] = lvl && (sel == dest_code(d));
   end
endmodule

// File: rtl/route_merge.sv
module route_merge #(
   parameter int NSRC  = 11,
   parameter int NDEST = 3
) (
   input  logic [NSRC*NDEST-1:0] hits,
   output logic [NDEST-1:0]      any_hit
);
   always_comb begin
      any_hit = '0;
      for (int s = 0; s < NSRC; s++) begin
         any_hit = any_hit | hits[s*NDEST +: NDEST];
      end
   end
endmodule

// File: rtl/pin_route_matrix.sv
module pin_route_matrix
   import route_pkg::*;
#(
   parameter int NUM_PINS    = 10,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS-1:0]       pin_lvl,
   input  logic                      pb_lvl,
   input  logic [NUM_PINS*SEL_W-1:0] pin_sel,
   input  logic [SEL_W-1:0]          pb_sel,
   output logic                      tmr0_clk,
   output logic                      tmr1_clk,
   output logic                      irq_hi
);
   localparam int NSRC = NUM_PINS + 1;

   generate
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("pin_route_matrix needs at least one pin");
      end
      if (SEL_W != CODE_W) begin : g_bad_w
         $error("pin_route_matrix selector width must be 3");
      end
   endgenerate

   logic [NSRC-1:0]       src_raw;
   logic [NSRC-1:0]       src_sync;
   logic [NSRC*SEL_W-1:0] src_sel;
   logic [NSRC*NDEST-1:0] hits;
   logic [NDEST-1:0]      dst;

   assign src_raw = {pb_lvl, pin_lvl};
   assign src_sel = {pb_sel, pin_sel};

   route_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_raw),
      .q     (src_sync)
   );

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      route_decode #(.SEL_W(SEL_W)) u_dec (
         .lvl (src_sync[s]),
         .sel (src_sel[s*SEL_W +: SEL_W]),
         .hit (hits[s*NDEST +: NDEST])
      );
   end

   route_merge #(.NSRC(NSRC), .NDEST(NDEST)) u_merge (
      .hits    (hits),
      .any_hit (dst)
   );

   assign tmr0_clk = dst[0];
   assign tmr1_clk = dst[1];
   assign irq_hi   = dst[2];
endmodule

// File: rtl/route_matrix_chk.sv
module route_matrix_chk #(
   parameter int NUM_PINS = 10,
   parameter int SEL_W    = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_PINS-1:0]       pin_lvl,
   input logic                      pb_lvl,
   input logic [NUM_PINS*SEL_W-1:0] pin_sel,
   input logic [SEL_W-1:0]          pb_sel,
   input logic                      tmr0_clk,
   input logic                      tmr1_clk,
   input logic                      irq_hi
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end
   wire rdy = (since_rst >= 2'd2);

   logic any2, any3, any4;
   always_comb begin
      any2 = (pb_sel == 3'd2);
      any3 = (pb_sel == 3'd3);
      any4 = (pb_sel == 3'd4);
      for (int k = 0; k < NUM_PINS; k++) begin
         any2 = any2 | (pin_sel[k*SEL_W +: SEL_W] == 3'd2);
         any3 = any3 | (pin_sel[k*SEL_W +: SEL_W] == 3'd3);
         any4 = any4 | (pin_sel[k*SEL_W +: SEL_W] == 3'd4);
      end
   end

   // R1: outputs quiet during reset
   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!tmr0_clk && !tmr1_clk && !irq_hi);
      end
   end

   p_t0_needs_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tmr0_clk |-> any2);
   p_t1_needs_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tmr1_clk |-> any3);
   p_irq_needs_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi |-> any4);

   // R6 / R7: push-button level reaches timer 0 after two edges
   p_pb_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && pb_sel == 3'd2 && $past(pb_lvl, 2)) |-> tmr0_clk);

   // R8 / R7: each pin reaches the interrupt through its own field
   for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
      p_pin_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (rdy && pin_sel[k*SEL_W +: SEL_W] == 3'd4 && $past(pin_lvl[k], 2)) |-> irq_hi);
   end
endmodule

bind pin_route_matrix route_matrix_chk #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/test_pin_route_matrix.sv
module test_pin_route_matrix;
   localparam int NP = 10;
   localparam int NS = NP + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_lvl = '0;
   logic          pb_lvl = 1'b0;
   logic [NP*3-1:0] pin_sel = '0;
   logic [2:0]    pb_sel = '0;
   logic          tmr0_clk, tmr1_clk, irq_hi;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pin_route_matrix i_pin_route_matrix (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pb_lvl(pb_lvl),
      .pin_sel(pin_sel), .pb_sel(pb_sel),
      .tmr0_clk(tmr0_clk), .tmr1_clk(tmr1_clk), .irq_hi(irq_hi)
   );

   // expected {irq, tmr1, tmr0} from levels and codes
   function automatic logic [2:0] expect_out(input logic [NS-1:0] lv, input logic [NS*3-1:0] sl);
      logic [2:0] e = 3'b000;
      for (int s = 0; s < NS; s++) begin
         if (lv[s]) begin
            case (sl[s*3 +: 3])
               3'd2: e[0] = 1'b1;
               3'd3: e[1] = 1'b1;
               3'd4: e[2] = 1'b1;
               default: ;
            endcase
         end
      end
      return e;
   endfunction

   task automatic chk(input string req, input logic [2:0] exp);
      logic [2:0] got = {irq_hi, tmr1_clk, tmr0_clk};
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%b expected=%b", req, got, exp);
      end
   endtask

   task automatic drive(input logic [NS-1:0] lv, input logic [NS*3-1:0] sl);
      pin_lvl = lv[NP-1:0];
      pb_lvl  = lv[NS-1];
      pin_sel = sl[NP*3-1:0];
      pb_sel  = sl[NS*3-1 -: 3];
   endtask

   // drive at a falling edge, sample after two rising edges
   task automatic apply_chk(input string req, input logic [NS-1:0] lv, input logic [NS*3-1:0] sl);
      @(negedge clk);
      drive(lv, sl);
      @(negedge clk);
      @(negedge clk);
      chk(req, expect_out(lv, sl));
   endtask

   function automatic logic [31:0] xs(input logic [31:0] x);
      logic [31:0] y = x;
      y = y ^ (y << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   initial begin
      logic [31:0] r = 32'h1234_5678;
      logic [NS*3-1:0] sl;
      logic [NS-1:0] lv;

      // R1: busy inputs during reset
      drive('1, {11{3'd2}} | 33'h0);
      pin_sel = {5{6'b011_100}};
      repeat (3) @(negedge clk);
      chk("R1", 3'b000);
      drive('0, '0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 after release", 3'b000);

      // R2 R3 R4 R6 R8: each source alone through every code
      for (int s = 0; s < NS; s++) begin
         for (int c = 0; c < 8; c++) begin
            for (int l = 0; l < 2; l++) begin
               sl = '0;
               sl[s*3 +: 3] = c[2:0];
               lv = '0;
               lv[s] = l[0];
               if (c < 2)       apply_chk(s == NS-1 ? "R6 R2" : "R8 R2", lv, sl);
               else if (c < 5)  apply_chk(s == NS-1 ? "R6 R3" : "R8 R3", lv, sl);
               else             apply_chk(s == NS-1 ? "R6 R4" : "R8 R4", lv, sl);
            end
         end
      end

      // R5: colliding sources merged by OR
      for (int i = 0; i < 60; i++) begin
         r = xs(r); lv = r[NS-1:0];
         r = xs(r); sl[31:0] = r;
         r = xs(r); sl[32] = r[0];
         apply_chk("R5", lv, sl);
      end
      sl = '0;
      sl[2:0] = 3'd2; sl[5:3] = 3'd2; sl[8:6] = 3'd3;
      apply_chk("R5 one of two high", 11'b000_0000_0010, sl);
      apply_chk("R5 both low", 11'b000_0000_0000, sl);

      // R7: two-edge latency on levels, immediate effect of codes
      sl = '0; sl[32:30] = 3'd2;
      apply_chk("R7 setup", '0, sl);
      @(negedge clk);
      pb_lvl = 1'b1;
      @(negedge clk);
      chk("R7 one edge", 3'b000);
      @(negedge clk);
      chk("R7 two edges", 3'b001);
      pb_sel = 3'd3;
      #1;
      chk("R7 code change", 3'b010);
      pb_sel = 3'd4;
      #1;
      chk("R7 code change irq", 3'b100);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog got=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule